// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a synchronous host and an asynchronous static memory of 128K bytes. The host raises a request strobe with a direction bit, an address and, for writes, a data byte. The controller then plays out the memory's control sequence over a fixed number of clock cycles and ends each access with a one-cycle done pulse. Reads return the byte on a registered read-data output.

Its memory side drives two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. It also drives the address bus and a shared, tri-stated data bus. Access times given in picoseconds are turned into whole wait cycles at elaboration, always rounding up. Between accesses the memory is deselected and the bus is released, so the device sits in standby.

The write path never drives the bus while the memory may be driving it. The output enable goes high first, one turnaround cycle follows, and only then does the controller enable its data driver. Data is committed on the rising edge of the write strobe. Address and data stay put for one more cycle after that edge.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever idle: mem_ce1_no=1, mem_ce2_o=0, mem_we_no=1, mem_oe_no=1, busy_o=0, done_o=0, data driver off.
- R2: A read request accepted at a clock edge gives one setup cycle (chip selected, OE high, WE high), then RD_CYC cycles with OE low and WE high. RD_CYC is the larger of ceil(T_CYCLE_PS/CLK_PERIOD_PS) and ceil(T_OE_PS/CLK_PERIOD_PS); it is 2 at the defaults.
- R3: The data bus is registered on the last OE-low cycle. It shows on rdata_o in the done cycle and is held until the next read completes.
- R4: A write request gives one setup cycle (chip selected, OE high, WE high, driver off). Then come WR_CYC cycles with WE low, where WR_CYC = ceil(T_CYCLE_PS/CLK_PERIOD_PS), which is 2 at the defaults. Then comes one hold cycle with WE high and the chip still selected.
- R5: The data bus carries the write byte throughout WE low and in the hold cycle, so the memory stores it at the WE rising edge.
- R6: The controller drives the bus only while OE is high. OE and WE are never low together.
- R7: mem_addr_o equals the accepted address from the setup cycle through the done cycle and does not change while busy.
- R8: A request raised while busy_o is high is ignored. No second access follows and memory contents are untouched.
- R9: After each access one done cycle follows with the chip deselected. The block then returns to idle.
- R10: done_o pulses for exactly one cycle per accepted request. busy_o is high from the setup cycle through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Registered read byte |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_addr_o | output | 17 | Memory address bus |
| mem_dq_io | inout | 8 | Shared data bus |

## Verification
A new host request can arrive in the same cycle as the tail of a running access. That tail may be the last OE-low read cycle that captures data, or the done cycle. The bench holds a write request high from the setup cycle of a read until its done cycle. It then checks four things: the read still returns the right byte, done pulses once, the block goes back to idle, and the targeted location keeps its old value. The same overlap arises when the write strobe rises while the bus driver is still on. The bench's memory model stores on that rising edge, and the bench compares the stored byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SETUP, ST_RD_WAIT, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_DONE
  } state_e;

  function automatic int unsigned ceil_cycles(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned CW     = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          expired_i,
  output state_e        state_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o
);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        state_d  = we_i ? ST_WR_SETUP : ST_RD_SETUP;
      end
      ST_RD_SETUP: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = RD_LOAD;
        state_d    = ST_RD_WAIT;
      end
      ST_RD_WAIT: if (expired_i) begin
        capture_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_WR_SETUP: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = WR_LOAD;
        state_d    = ST_WR_PULSE;
      end
      ST_WR_PULSE: if (expired_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R10: completion leaves immediately
  a_r10_done_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
  // R2: strobe phase always preceded by its setup
  a_r2_setup_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RD_WAIT) |-> $past(state_q == ST_RD_SETUP));
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= bus_i;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned DW          = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_CYCLE_PS  = 12000,
  parameter int unsigned T_OE_PS     = 6000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_ce1_no,
  output logic          mem_ce2_o,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [AW-1:0] mem_addr_o,
  inout  wire  [DW-1:0] mem_dq_io
);
  localparam int unsigned RD_CYC = max_u(ceil_cycles(T_CYCLE_PS, CLK_PERIOD_PS),
                                         ceil_cycles(T_OE_PS, CLK_PERIOD_PS));
  localparam int unsigned WR_CYC = ceil_cycles(T_CYCLE_PS, CLK_PERIOD_PS);
  localparam int unsigned CW     = $clog2(max_u(RD_CYC, WR_CYC) + 1);

  state_e        state;
  logic          accept, capture, tmr_load, expired, drv_en, sel;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] wdata_q;

  sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CW(CW)) fsm_i (
    .clk_i, .rst_ni, .req_i, .we_i,
    .expired_i (expired),
    .state_o   (state),
    .accept_o  (accept),
    .capture_o (capture),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val)
  );

  sram_wait_timer #(.CW(CW)) timer_i (
    .clk_i, .rst_ni,
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (expired)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW)) dp_i (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .capture_i(capture),
    .addr_i, .wdata_i,
    .bus_i    (mem_dq_io),
    .addr_o   (mem_addr_o),
    .wdata_o  (wdata_q),
    .rdata_o
  );

  always_comb begin
    sel       = 1'b0;
    mem_oe_no = 1'b1;
    mem_we_no = 1'b1;
    drv_en    = 1'b0;
    unique case (state)
      ST_RD_SETUP, ST_WR_SETUP: sel = 1'b1;
      ST_RD_WAIT:  begin sel = 1'b1; mem_oe_no = 1'b0; end
      ST_WR_PULSE: begin sel = 1'b1; mem_we_no = 1'b0; drv_en = 1'b1; end
      ST_WR_HOLD:  begin sel = 1'b1; drv_en = 1'b1; end
      default: ;
    endcase
  end

  assign mem_ce1_no = ~sel;
  assign mem_ce2_o  = sel;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign mem_dq_io  = drv_en ? wdata_q : {DW{1'bz}};

  a_r6_no_strobe_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  a_r6_drive_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en |-> mem_oe_no);
  // R4: driver enabled only after a selected cycle with OE high
  a_r4_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en) |-> $past(!mem_ce1_no && mem_oe_no && !drv_en));
  a_r7_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mem_ce1_no && !mem_ce2_o && mem_we_no && mem_oe_no));
endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int RD_CYC = 2;  // max(ceil(12/10), ceil(6/10))
  localparam int WR_CYC = 2;  // ceil(12/10)

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy, done, ce1_n, ce2, we_n, oe_n;
  logic [16:0] maddr;
  wire  [7:0]  dq;

  logic [7:0] mem [0:255];
  logic       mem_drv;

  int checks = 0, errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .mem_ce1_no(ce1_n), .mem_ce2_o(ce2), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_addr_o(maddr), .mem_dq_io(dq)
  );

  // Memory model
  assign mem_drv = !ce1_n && ce2 && !oe_n && we_n;
  assign dq = mem_drv ? mem[maddr[7:0]] : 8'bz;
  always @(posedge we_n) if (!ce1_n && ce2) mem[maddr[7:0]] <= dq;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(ce1_n == 1 && ce2 == 0, {tag, " chip deselected"}, {ce1_n, ce2}, 2'b10);
    chk(we_n == 1 && oe_n == 1, {tag, " strobes high"}, {we_n, oe_n}, 2'b11);
    chk(busy == 0 && done == 0, {tag, " busy/done low"}, {busy, done}, 0);
  endtask

  task automatic t_reset();
    chk_idle("R1 reset");
  endtask

  task automatic t_read(input logic [16:0] a, input logic [7:0] exp, input bit hold_req);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk);
    if (hold_req) begin we = 1; addr = a ^ 17'h1; wdata = 8'hEE; end else req = 0;
    chk(!ce1_n && ce2 && oe_n && we_n, "R2 read setup", {ce1_n, ce2, oe_n, we_n}, 4'b0111);
    chk(busy && !done, "R10 busy in setup", {busy, done}, 2'b10);
    chk(maddr == a, "R7 addr setup", maddr, a);
    for (int i = 0; i < RD_CYC; i++) begin
      @(negedge clk);
      chk(!oe_n && we_n && !ce1_n, "R2 oe low phase", {oe_n, we_n, ce1_n}, 3'b010);
      chk(maddr == a, "R7 addr in strobe", maddr, a);
    end
    @(negedge clk);
    if (hold_req) req = 0;
    chk(done && busy, "R10 done pulse", {done, busy}, 2'b11);
    chk(rdata == exp, "R3 read data", rdata, exp);
    chk(ce1_n && !ce2 && oe_n, "R9 deselect in done", {ce1_n, ce2, oe_n}, 3'b101);
    @(negedge clk);
    chk_idle("R9 back to idle");
    if (hold_req) begin
      @(negedge clk);
      chk(!busy, "R8 ignored request no access", busy, 0);
      chk(mem[(a ^ 17'h1) & 17'hFF] == 8'h5A, "R8 memory untouched",
          mem[(a ^ 17'h1) & 17'hFF], 8'h5A);
    end
  endtask

  task automatic t_write(input logic [16:0] a, input logic [7:0] d);
    logic [7:0] rd_before;
    rd_before = rdata;
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; addr = '1; wdata = ~d;
    chk(!ce1_n && ce2 && oe_n && we_n, "R4 write setup", {ce1_n, ce2, oe_n, we_n}, 4'b0111);
    chk(maddr == a, "R7 addr write setup", maddr, a);
    for (int i = 0; i < WR_CYC; i++) begin
      @(negedge clk);
      chk(!we_n && oe_n, "R4 we low phase", {we_n, oe_n}, 2'b01);
      chk(dq == d, "R5 bus carries data", dq, d);
      chk(oe_n == 1, "R6 no drive with oe low", oe_n, 1);
    end
    @(negedge clk);
    chk(we_n && !ce1_n && ce2, "R4 hold cycle", {we_n, ce1_n, ce2}, 3'b101);
    chk(dq == d && maddr == a, "R5 data/addr held", {maddr, dq}, {a, d});
    @(negedge clk);
    chk(done, "R10 write done", done, 1);
    chk(mem[a[7:0]] == d, "R5 stored at we rise", mem[a[7:0]], d);
    chk(rdata == rd_before, "R3 rdata held over write", rdata, rd_before);
    @(negedge clk);
    chk_idle("R9 idle after write");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h5A;
    mem[8'h34] = 8'hC3;
    #(3*CLK_NS) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read(17'h10034, 8'hC3, 1'b0);
    t_write(17'h00077, 8'hA5);
    t_read(17'h00077, 8'hA5, 1'b0);
    t_write(17'h1FF00, 8'h00);
    t_write(17'h000FF, 8'hFF);
    t_read(17'h1FF00, 8'h00, 1'b0);
    t_read(17'h000FF, 8'hFF, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5000*CLK_NS);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule